// File: doc/BRIEF.md
# Dual-Range Autoranging Measurement Sequencer

This block runs one measurement channel of a converter that has two gain ranges, fine and coarse. On each time-slice trigger it first asks the external converter for a fine-range sample. If that sample lies above the fine ceiling, the fine sample is dropped and a coarse-range sample is requested instead. The accepted raw code is then right-shifted, multiplied by a gain and shifted by a signed offset. Each range has its own shift, gain and offset. The final value is saturated and written to a single result register. A flag records which range produced the value.

Two policies decide where the ranges meet. In hysteresis mode, the fine ceiling and the coarse floor both come from the fine shift count. In crossover mode, both limits come from configuration inputs. Two force bits can pin the channel to one range, which is useful during calibration.

Top module: `dual_range_seq`

## Requirements
- R1: Each time slice that is not forced to the coarse range begins with a fine request (`conv_req`=1, `conv_coarse`=0) in the cycle after `start` is accepted.
- R2: In autorange mode, a fine raw code at or below the fine ceiling is reported with `result_coarse`=0. A fine code above the ceiling triggers exactly one coarse request, and that coarse result is reported with `result_coarse`=1.
- R3: When `cfg_xover_en`=0 (hysteresis), the fine ceiling is 16'hFFF8 >> n and the coarse floor is 16'hF000 >> n, where n is `cfg_fine_shift`.
- R4: When `cfg_xover_en`=1 (crossover), the fine ceiling is `cfg_fine_max` and the coarse floor is `cfg_coarse_min`.
- R5: In autorange mode, a coarse raw code below the coarse floor is raised to the floor before shifting.
- R6: Force bits {`cfg_force_coarse`,`cfg_force_fine`} select the policy. 00 is autorange. 01 and 11 give fine only: one fine conversion, reported unchanged with flag 0 whatever its size. 10 gives coarse only: one coarse conversion, no floor applied, flag 1.
- R7: The reported value is computed as follows. Shift the raw code right by that range's shift. Multiply by that range's unsigned gain, in which 16'h0100 means 1.0. Add that range's 16-bit two's-complement offset. Saturate the sum to the range 0 to 16'hFFFF.
- R8: `result_data` and `result_coarse` change together, on the same edge where `result_valid` pulses for one cycle. At all other times they hold their values.
- R9: A `start` pulse that arrives while a slice is in progress is ignored and issues no further conversion.
- R10: After reset, `result_data`=0, `result_coarse`=0, `result_valid`=0 and `conv_req`=0.
- R11: Once raised, `conv_req` stays high and `conv_coarse` stays stable until `conv_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Time-slice trigger |
| cfg_xover_en | input | 1 | 1 = crossover limits from inputs, 0 = hysteresis limits |
| cfg_force_coarse | input | 1 | Force-coarse bit |
| cfg_force_fine | input | 1 | Force-fine bit |
| cfg_fine_shift | input | 3 | Fine right-shift count (also hysteresis index) |
| cfg_coarse_shift | input | 3 | Coarse right-shift count |
| cfg_fine_max | input | 16 | Crossover fine ceiling (raw code) |
| cfg_coarse_min | input | 16 | Crossover coarse floor (raw code) |
| cfg_fine_gain | input | 16 | Fine gain, 8 fractional bits |
| cfg_fine_offset | input | 16 | Fine signed offset |
| cfg_coarse_gain | input | 16 | Coarse gain, 8 fractional bits |
| cfg_coarse_offset | input | 16 | Coarse signed offset |
| conv_req | output | 1 | Conversion request to converter |
| conv_coarse | output | 1 | Range of the requested conversion (1 = coarse) |
| conv_done | input | 1 | One-cycle completion strobe from converter |
| conv_data | input | 16 | Raw code, valid with `conv_done` |
| result_data | output | 16 | Reported measurement |
| result_coarse | output | 1 | 1 when the reported value came from the coarse range |
| result_valid | output | 1 | One-cycle strobe when the result updates |

## Verification
The bench sweeps all eight shift counts in hysteresis mode. At each count it places the fine code exactly on the ceiling and one above it, and places the coarse code just below and just above the floor. An off-by-one compare or a wrong table entry would therefore flip the reported range or skip the floor clamp. Crossover limits, every force-bit combination, gains that overflow and negative offsets are also driven. These catch a design that ignores a force bit, that wraps instead of saturating, or that shifts with the wrong range's count. A second `start` inside a slice, and the stability of the result between strobes, are checked through the conversion counts and the result ports.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FINE, ST_COARSE, ST_SCALE} drs_state_e;
  typedef enum logic [1:0] {POL_AUTO, POL_FINE, POL_COARSE} drs_policy_e;

  function automatic drs_policy_e decode_policy(input logic force_coarse, input logic force_fine);
    if (force_fine)        return POL_FINE;
    else if (force_coarse) return POL_COARSE;
    else                   return POL_AUTO;
  endfunction
endpackage

// File: rtl/drs_limits.sv
module drs_limits #(
  parameter int DATA_W = 16,
  parameter int SHIFT_W = 3,
  parameter logic [DATA_W-1:0] HYST_FINE_TOP = 16'hFFF8,
  parameter logic [DATA_W-1:0] HYST_COARSE_TOP = 16'hF000
) (
  input  logic               xover_en,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [DATA_W-1:0]  reg_fine_max,
  input  logic [DATA_W-1:0]  reg_coarse_min,
  output logic [DATA_W-1:0]  fine_max,
  output logic [DATA_W-1:0]  coarse_min
);
  localparam int NUM_SHIFTS = 1 << SHIFT_W;

  logic [DATA_W-1:0] hyst_fine [NUM_SHIFTS];
  logic [DATA_W-1:0] hyst_coarse [NUM_SHIFTS];

  // Hysteresis limits scale with the fine shift count.
  for (genvar i = 0; i < NUM_SHIFTS; i++) begin : g_tbl
    assign hyst_fine[i]   = HYST_FINE_TOP >> i;
    assign hyst_coarse[i] = HYST_COARSE_TOP >> i;
  end

  always_comb begin
    if (xover_en) begin
      fine_max   = reg_fine_max;
      coarse_min = reg_coarse_min;
    end else begin
      fine_max   = hyst_fine[shift];
      coarse_min = hyst_coarse[shift];
    end
  end
endmodule

// File: rtl/drs_scaler.sv
module drs_scaler #(
  parameter int DATA_W = 16,
  parameter int SHIFT_W = 3,
  parameter int GAIN_W = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic [DATA_W-1:0]  raw,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [GAIN_W-1:0]  gain,
  input  logic [DATA_W-1:0]  offset,
  output logic [DATA_W-1:0]  scaled
);
  localparam int PROD_W = DATA_W + GAIN_W;
  localparam int SUM_W  = PROD_W + 2;

  logic [PROD_W-1:0]       prod;
  logic [PROD_W-1:0]       prod_sh;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    prod    = PROD_W'(raw >> shift) * PROD_W'(gain);
    prod_sh = prod >> GAIN_FRAC;
    sum     = $signed({2'b00, prod_sh}) +
              $signed({{(SUM_W-DATA_W){offset[DATA_W-1]}}, offset});
    if (sum[SUM_W-1])
      scaled = '0;
    else if (|sum[SUM_W-2:DATA_W])
      scaled = '1;
    else
      scaled = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/dual_range_seq.sv
module dual_range_seq
  import drs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHIFT_W = 3,
  parameter int GAIN_W = 16,
  parameter int GAIN_FRAC = 8,
  parameter logic [DATA_W-1:0] HYST_FINE_TOP = 16'hFFF8,
  parameter logic [DATA_W-1:0] HYST_COARSE_TOP = 16'hF000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cfg_xover_en,
  input  logic               cfg_force_coarse,
  input  logic               cfg_force_fine,
  input  logic [SHIFT_W-1:0] cfg_fine_shift,
  input  logic [SHIFT_W-1:0] cfg_coarse_shift,
  input  logic [DATA_W-1:0]  cfg_fine_max,
  input  logic [DATA_W-1:0]  cfg_coarse_min,
  input  logic [GAIN_W-1:0]  cfg_fine_gain,
  input  logic [DATA_W-1:0]  cfg_fine_offset,
  input  logic [GAIN_W-1:0]  cfg_coarse_gain,
  input  logic [DATA_W-1:0]  cfg_coarse_offset,
  output logic               conv_req,
  output logic               conv_coarse,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic [DATA_W-1:0]  result_data,
  output logic               result_coarse,
  output logic               result_valid
);
  drs_state_e        state;
  drs_policy_e       pol_q;
  drs_policy_e       pol_in;
  logic [DATA_W-1:0] raw_q;
  logic              coarse_q;
  logic [DATA_W-1:0] fine_max;
  logic [DATA_W-1:0] coarse_min;
  logic [DATA_W-1:0] scaled;
  logic [SHIFT_W-1:0] sel_shift;
  logic [GAIN_W-1:0]  sel_gain;
  logic [DATA_W-1:0]  sel_offset;

  assign pol_in = decode_policy(cfg_force_coarse, cfg_force_fine);

  drs_limits #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W),
    .HYST_FINE_TOP(HYST_FINE_TOP), .HYST_COARSE_TOP(HYST_COARSE_TOP)
  ) u_limits (
    .xover_en(cfg_xover_en), .shift(cfg_fine_shift),
    .reg_fine_max(cfg_fine_max), .reg_coarse_min(cfg_coarse_min),
    .fine_max(fine_max), .coarse_min(coarse_min)
  );

  always_comb begin
    sel_shift  = coarse_q ? cfg_coarse_shift  : cfg_fine_shift;
    sel_gain   = coarse_q ? cfg_coarse_gain   : cfg_fine_gain;
    sel_offset = coarse_q ? cfg_coarse_offset : cfg_fine_offset;
  end

  drs_scaler #(
    .DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
  ) u_scaler (
    .raw(raw_q), .shift(sel_shift), .gain(sel_gain),
    .offset(sel_offset), .scaled(scaled)
  );

  assign conv_req    = (state == ST_FINE) || (state == ST_COARSE);
  assign conv_coarse = (state == ST_COARSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pol_q         <= POL_AUTO;
      raw_q         <= '0;
      coarse_q      <= 1'b0;
      result_data   <= '0;
      result_coarse <= 1'b0;
      result_valid  <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          pol_q <= pol_in;
          state <= (pol_in == POL_COARSE) ? ST_COARSE : ST_FINE;
        end
        ST_FINE: if (conv_done) begin
          if (pol_q == POL_AUTO && conv_data > fine_max) begin
            state <= ST_COARSE;
          end else begin
            raw_q    <= conv_data;
            coarse_q <= 1'b0;
            state    <= ST_SCALE;
          end
        end
        ST_COARSE: if (conv_done) begin
          raw_q    <= (pol_q == POL_AUTO && conv_data < coarse_min) ? coarse_min : conv_data;
          coarse_q <= 1'b1;
          state    <= ST_SCALE;
        end
        ST_SCALE: begin
          result_data   <= scaled;
          result_coarse <= coarse_q;
          result_valid  <= 1'b1;
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: request held, range stable, until completion
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_done |=> conv_req && $stable(conv_coarse));

  // R1: a slice not forced coarse opens with a fine request
  p_fine_first_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE && start && pol_in != POL_COARSE |=> conv_req && !conv_coarse);

  // R2: an oversized fine sample in autorange moves to a coarse request
  p_overrange_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_FINE && conv_done && pol_q == POL_AUTO && conv_data > fine_max
    |=> conv_req && conv_coarse);

  // R8: strobe lasts a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R8: outputs hold outside the update cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result_data) && $stable(result_coarse));

  // R9: start mid-slice does not restart the fine request
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    state == ST_COARSE && start && !conv_done |=> state == ST_COARSE);
endmodule

// File: tb/dual_range_seq_bench.sv
`timescale 1ns/1ps
module dual_range_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic xover = 1'b0, fcoarse = 1'b0, ffine = 1'b0;
  logic [2:0] fshift = '0, cshift = '0;
  logic [15:0] rfmax = '0, rcmin = '0;
  logic [15:0] fgain = 16'h0100, foff = '0, cgain = 16'h0100, coff = '0;
  logic conv_req, conv_coarse;
  logic conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic [15:0] result_data;
  logic result_coarse, result_valid;

  int checks = 0, errors = 0;
  int n_fine = 0, n_coarse = 0;
  logic first_coarse = 1'b0;
  logic [15:0] fine_code = '0, coarse_code = '0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_range_seq u_dual_range_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_xover_en(xover), .cfg_force_coarse(fcoarse), .cfg_force_fine(ffine),
    .cfg_fine_shift(fshift), .cfg_coarse_shift(cshift),
    .cfg_fine_max(rfmax), .cfg_coarse_min(rcmin),
    .cfg_fine_gain(fgain), .cfg_fine_offset(foff),
    .cfg_coarse_gain(cgain), .cfg_coarse_offset(coff),
    .conv_req(conv_req), .conv_coarse(conv_coarse),
    .conv_done(conv_done), .conv_data(conv_data),
    .result_data(result_data), .result_coarse(result_coarse),
    .result_valid(result_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Converter model: answers each request after a few cycles
  initial begin
    int cnt = 0;
    bit active = 0;
    logic rng = 0;
    forever begin
      @(negedge clk);
      if (conv_done) conv_done = 1'b0;
      else if (active) begin
        if (!conv_req || conv_coarse != rng) begin
          errors++; checks++;
          $display("FAIL R11: actual req=%0b rng=%0b expected req=1 rng=%0b", conv_req, conv_coarse, rng);
        end
        cnt--;
        if (cnt == 0) begin
          conv_done = 1'b1;
          conv_data = rng ? coarse_code : fine_code;
          active = 0;
        end
      end else if (conv_req) begin
        active = 1; cnt = 3; rng = conv_coarse;
        if (n_fine + n_coarse == 0) first_coarse = rng;
        if (rng) n_coarse++; else n_fine++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  function automatic logic [15:0] scale(input logic [15:0] raw, input logic [2:0] sh,
                                        input logic [15:0] g, input logic [15:0] o);
    longint p, s;
    p = (longint'(raw >> sh) * longint'(g)) >>> 8;
    s = p + longint'($signed(o));
    if (s < 0) return 16'h0;
    if (s > 65535) return 16'hFFFF;
    return s[15:0];
  endfunction

  task automatic slice(input string tag, input logic [15:0] f, input logic [15:0] c,
                       input bit extra_start);
    logic [15:0] fmax, cmin, v, exp_v;
    logic exp_fl;
    int exp_nf, exp_nc, w;
    fmax = xover ? rfmax : (16'hFFF8 >> fshift);
    cmin = xover ? rcmin : (16'hF000 >> fshift);
    if (ffine) begin
      v = f; exp_fl = 0; exp_nf = 1; exp_nc = 0;
    end else if (fcoarse) begin
      v = c; exp_fl = 1; exp_nf = 0; exp_nc = 1;
    end else if (f <= fmax) begin
      v = f; exp_fl = 0; exp_nf = 1; exp_nc = 0;
    end else begin
      v = (c < cmin) ? cmin : c; exp_fl = 1; exp_nf = 1; exp_nc = 1;
    end
    exp_v = exp_fl ? scale(v, cshift, cgain, coff) : scale(v, fshift, fgain, foff);
    fine_code = f; coarse_code = c;
    n_fine = 0; n_coarse = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!result_valid && w < 200) begin
      if (extra_start && w == 4) start = 1'b1;
      else start = 1'b0;
      @(negedge clk); w++;
    end
    start = 1'b0;
    chk({tag, " R8 valid strobe"}, result_valid, 1);
    chk({tag, " R7 value"}, result_data, exp_v);
    chk({tag, " R2 range flag"}, result_coarse, exp_fl);
    chk({tag, " R2 fine conversions"}, n_fine, exp_nf);
    chk({tag, " R2 coarse conversions"}, n_coarse, exp_nc);
    if (exp_nf == 1) chk({tag, " R1 fine first"}, first_coarse, 0);
    repeat (8) @(negedge clk);
    chk({tag, " R9 no extra conversion"}, n_fine + n_coarse, exp_nf + exp_nc);
    chk({tag, " R8 hold value"}, result_data, exp_v);
    chk({tag, " R8 valid low"}, result_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 result", result_data, 0);
    chk("R10 flag", result_coarse, 0);
    chk("R10 valid", result_valid, 0);
    chk("R10 req", conv_req, 0);
    rst = 1'b0;

    // R3/R5 hysteresis sweep over every shift count
    for (int n = 0; n < 8; n++) begin
      logic [15:0] fm, cm;
      fshift = 3'(n); cshift = 3'(7 - n);
      fm = 16'hFFF8 >> n; cm = 16'hF000 >> n;
      slice("R3 at ceiling", fm, 16'h0000, 0);
      slice("R3 above ceiling R5 below floor", fm + 16'd1, cm - 16'd1, 0);
      slice("R3 above ceiling R5 above floor", fm + 16'd1, cm + 16'd5, 0);
    end

    // R4 crossover limits from inputs
    xover = 1'b1; rfmax = 16'h1234; rcmin = 16'h2000; fshift = 3'd1; cshift = 3'd2;
    slice("R4 at ceiling", 16'h1234, 16'h0, 0);
    slice("R4 above ceiling", 16'h1235, 16'h1FFF, 0);
    slice("R4 coarse ok", 16'hFFFF, 16'h8000, 0);
    xover = 1'b0;

    // R6 force bits
    fshift = 3'd0; cshift = 3'd0;
    ffine = 1'b1; fcoarse = 1'b0;
    slice("R6 force fine", 16'hFFFF, 16'h1111, 0);
    ffine = 1'b1; fcoarse = 1'b1;
    slice("R6 both set", 16'hFFFE, 16'h1111, 0);
    ffine = 1'b0; fcoarse = 1'b1;
    slice("R6 force coarse", 16'h0001, 16'h0010, 0);
    fcoarse = 1'b0;

    // R7 gain and offset
    fgain = 16'h0300; foff = 16'h0000;
    slice("R7 saturate high", 16'h8000, 16'h0, 0);
    fgain = 16'h0080; foff = 16'hFF00;
    slice("R7 saturate low", 16'h0100, 16'h0, 0);
    fgain = 16'h0180; foff = 16'h0010; fshift = 3'd2;
    slice("R7 fractional", 16'h1000, 16'h0, 0);
    cgain = 16'h0200; coff = 16'h8000; cshift = 3'd3;
    slice("R7 coarse neg offset", 16'hFFFF, 16'hF800, 0);

    // R9 start during a slice
    fgain = 16'h0100; foff = 16'h0; cgain = 16'h0100; coff = 16'h0;
    slice("R9 fine slice restart", 16'h0100, 16'h0, 1);
    slice("R9 coarse slice restart", 16'hFFFF, 16'hFF00, 1);

    finished = 1;
    finish_sim();
  end
endmodule